// File: doc/BRIEF.md
# Sequential Page Read Engine

This block sequences reads from a page-organised read-only array. A start request gives a read mode, a page number and a starting byte. The engine then goes busy and asks the array to load that page into its data register. When the load interval ends, it reports ready and streaming. From then on, each read strobe from the host moves the column on by one byte.

After the last byte of a page, the engine goes busy again, loads the next page and carries on. The column it resumes at depends on the mode: the whole page or only its spare tail. Auto-increment never leaves the 32-page block that holds the starting page. After the final byte of that block's last page, the engine stops and waits for a new start. An abort command cancels any activity and holds the engine busy for a reset interval.

The array itself, pin decoding and output driver timing sit outside this block. Each page holds 528 bytes: columns 0 to 511 are main data and columns 512 to 527 are spare bytes.

Top module: `seqrd_engine`

## Requirements
- R1: A start accepted while not busy sets `page` to `start_page` and sets `col` from `start_mode` and `start_byte`. Mode code 0 (and code 3) gives `start_byte`. Mode code 1 gives 256 + `start_byte`. Mode code 2 gives 512 + `start_byte[3:0]`.
- R2: After an accepted start, `busy` is high for exactly LOAD_CYC cycles and then `streaming` rises. `load_req` pulses for one cycle in the first busy cycle.
- R3: While streaming, each cycle with `rd_pulse` high and `col` below 527 increments `col` by one.
- R4: A read strobe at column 527 of a page that is not the block's last page moves `page` on by one and starts a new busy interval of LOAD_CYC cycles, with a `load_req` pulse.
- R5: The new page starts at column 0 in mode codes 0, 1 and 3, and at column 512 in mode code 2.
- R6: A read strobe at column 527 of the block's last page stops the sequence. The block's last page is one whose low five page bits are all ones. After it the engine is not busy, not streaming and issues no `load_req`.
- R7: A read strobe while busy or stopped has no effect: `col` and `page` stay unchanged.
- R8: `dout` is FFh while streaming at a column of 512 or more. It equals `arr_data` while streaming at a lower column, and it is 00h when not streaming.
- R9: `abort` from any state makes `busy` high for exactly RST_CYC cycles, after which the engine is idle. `abort` wins over a start or a read strobe in the same cycle.
- R10: A start request while busy is ignored.
- R11: A start while streaming restarts the sequence at the new address, even when a read strobe arrives in the same cycle.
- R12: After reset the engine is idle: not busy, not streaming, no `load_req`, and `page` and `col` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request strobe |
| start_mode | input | 2 | Read mode code for the start |
| start_page | input | PAGE_W | Starting page number |
| start_byte | input | 8 | Starting byte within the selected area |
| abort | input | 1 | Abort command strobe |
| rd_pulse | input | 1 | Read strobe, one byte per high cycle |
| arr_data | input | 8 | Byte from the array data register at `col` |
| busy | output | 1 | High while a page load or reset interval runs |
| streaming | output | 1 | High while bytes may be read |
| load_req | output | 1 | One-cycle request to load `page` into the data register |
| page | output | PAGE_W | Current page |
| col | output | 10 | Current column |
| dout | output | 8 | Byte presented to the host |

## Verification
Three pairs of events can fall in the same cycle: a read strobe with a start, a read strobe with an abort, and a start with an abort. The bench drives all three pairs in single cycles, including a strobe on column 527 together with a start, and a start on the last cycle of a load interval. A behavioural model, written with integers and checked every clock, decides each result. The model gives abort precedence over start, and start precedence over the strobe.

// File: rtl/seqrd_pkg.sv
package seqrd_pkg;

    localparam int COL_W       = 10;
    localparam int MAIN_BYTES  = 512;
    localparam int HALF_BYTES  = 256;
    localparam int SPARE_BYTES = 16;
    localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES;
    localparam int SPARE_AW    = $clog2(SPARE_BYTES);
    localparam logic [COL_W-1:0] LAST_COL  = COL_W'(PAGE_BYTES - 1);
    localparam logic [COL_W-1:0] SPARE_COL = COL_W'(MAIN_BYTES);

    typedef enum logic [1:0] {
        MODE_LOW   = 2'd0,
        MODE_HIGH  = 2'd1,
        MODE_SPARE = 2'd2,
        MODE_ALT   = 2'd3
    } rdmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STREAM,
        ST_RESET
    } seq_state_e;

    function automatic logic [COL_W-1:0] entry_col(input rdmode_e m, input logic [7:0] b);
        logic [COL_W-1:0] c;
        case (m)
            MODE_HIGH:  c = COL_W'(HALF_BYTES) + COL_W'(b);
            MODE_SPARE: c = SPARE_COL + COL_W'(b[SPARE_AW-1:0]);
            default:    c = COL_W'(b);
        endcase
        return c;
    endfunction

    function automatic logic [COL_W-1:0] wrap_col(input rdmode_e m);
        return (m == MODE_SPARE) ? SPARE_COL : '0;
    endfunction

    function automatic logic in_spare(input logic [COL_W-1:0] c);
        return c >= SPARE_COL;
    endfunction

endpackage

// File: rtl/seqrd_timer.sv
module seqrd_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [CNT_W-1:0] arm_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (arm)
            cnt_q <= arm_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/seqrd_addr.sv
module seqrd_addr
    import seqrd_pkg::*;
#(
    parameter int PAGE_W   = 15,
    parameter int BLK_BITS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch,
    input  rdmode_e           latch_mode,
    input  logic [PAGE_W-1:0] latch_page,
    input  logic [7:0]        latch_byte,
    input  logic              step,
    input  logic              next_page,
    output logic [PAGE_W-1:0] page,
    output logic [COL_W-1:0]  col,
    output logic              col_last,
    output logic              page_last
);
    rdmode_e           mode_q;
    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_LOW;
            page_q <= '0;
            col_q  <= '0;
        end else if (latch) begin
            mode_q <= latch_mode;
            page_q <= latch_page;
            col_q  <= entry_col(latch_mode, latch_byte);
        end else if (next_page) begin
            page_q <= page_q + 1'b1;
            col_q  <= wrap_col(mode_q);
        end else if (step) begin
            col_q  <= col_q + 1'b1;
        end
    end

    assign page      = page_q;
    assign col       = col_q;
    assign col_last  = (col_q == LAST_COL);
    assign page_last = &page_q[BLK_BITS-1:0];
endmodule

// File: rtl/seqrd_ctrl.sv
module seqrd_ctrl
    import seqrd_pkg::*;
#(
    parameter int LOAD_CYC = 8,
    parameter int RST_CYC  = 12,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic             rd,
    input  logic             tmr_zero,
    input  logic             col_last,
    input  logic             page_last,
    output seq_state_e       state,
    output logic             arm,
    output logic [CNT_W-1:0] arm_val,
    output logic             latch,
    output logic             step,
    output logic             next_page,
    output logic             load_req
);
    seq_state_e st_q, st_n;
    logic       req_q;

    always_comb begin
        st_n      = st_q;
        arm       = 1'b0;
        arm_val   = '0;
        latch     = 1'b0;
        step      = 1'b0;
        next_page = 1'b0;
        if (abort) begin
            st_n    = ST_RESET;
            arm     = 1'b1;
            arm_val = CNT_W'(RST_CYC - 1);
        end else begin
            case (st_q)
                ST_IDLE, ST_STREAM: begin
                    if (start) begin
                        latch   = 1'b1;
                        arm     = 1'b1;
                        arm_val = CNT_W'(LOAD_CYC - 1);
                        st_n    = ST_LOAD;
                    end else if (st_q == ST_STREAM && rd) begin
                        if (!col_last) begin
                            step = 1'b1;
                        end else if (page_last) begin
                            st_n = ST_IDLE;
                        end else begin
                            next_page = 1'b1;
                            arm       = 1'b1;
                            arm_val   = CNT_W'(LOAD_CYC - 1);
                            st_n      = ST_LOAD;
                        end
                    end
                end
                ST_LOAD:  if (tmr_zero) st_n = ST_STREAM;
                ST_RESET: if (tmr_zero) st_n = ST_IDLE;
                default:  st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            req_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            req_q <= latch | next_page;
        end
    end

    assign state    = st_q;
    assign load_req = req_q;
endmodule

// File: rtl/seqrd_engine.sv
module seqrd_engine
    import seqrd_pkg::*;
#(
    parameter int PAGE_W    = 15,
    parameter int BLK_PAGES = 32,
    parameter int LOAD_CYC  = 8,
    parameter int RST_CYC   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        start_mode,
    input  logic [PAGE_W-1:0] start_page,
    input  logic [7:0]        start_byte,
    input  logic              abort,
    input  logic              rd_pulse,
    input  logic [7:0]        arr_data,
    output logic              busy,
    output logic              streaming,
    output logic              load_req,
    output logic [PAGE_W-1:0] page,
    output logic [9:0]        col,
    output logic [7:0]        dout
);
    localparam int BLK_BITS = $clog2(BLK_PAGES);
    localparam int MAX_CYC  = (LOAD_CYC > RST_CYC) ? LOAD_CYC : RST_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    seq_state_e       state;
    logic             arm, latch, step, next_page, tmr_zero;
    logic [CNT_W-1:0] arm_val;
    logic             col_last, page_last;
    logic [COL_W-1:0] col_i;

    seqrd_ctrl #(
        .LOAD_CYC(LOAD_CYC),
        .RST_CYC (RST_CYC),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .abort    (abort),
        .rd       (rd_pulse),
        .tmr_zero (tmr_zero),
        .col_last (col_last),
        .page_last(page_last),
        .state    (state),
        .arm      (arm),
        .arm_val  (arm_val),
        .latch    (latch),
        .step     (step),
        .next_page(next_page),
        .load_req (load_req)
    );

    seqrd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm),
        .arm_val(arm_val),
        .zero   (tmr_zero)
    );

    seqrd_addr #(
        .PAGE_W  (PAGE_W),
        .BLK_BITS(BLK_BITS)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .latch     (latch),
        .latch_mode(rdmode_e'(start_mode)),
        .latch_page(start_page),
        .latch_byte(start_byte),
        .step      (step),
        .next_page (next_page),
        .page      (page),
        .col       (col_i),
        .col_last  (col_last),
        .page_last (page_last)
    );

    assign busy      = (state == ST_LOAD) || (state == ST_RESET);
    assign streaming = (state == ST_STREAM);
    assign col       = col_i;
    assign dout      = !streaming      ? 8'h00 :
                       in_spare(col_i) ? 8'hFF : arr_data;
endmodule

// File: rtl/seqrd_checks.sv
module seqrd_checks #(
    parameter int PAGE_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              abort,
    input logic              rd_pulse,
    input logic              busy,
    input logic              streaming,
    input logic              load_req,
    input logic [PAGE_W-1:0] page,
    input logic [9:0]        col,
    input logic [7:0]        dout
);
    // R2
    load_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        load_req |-> busy);

    // R2
    busy_stream_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && streaming));

    // R3
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (streaming && rd_pulse && !start && !abort && col != 10'd527)
            |=> (col == $past(col) + 10'd1));

    // R6
    block_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (streaming && rd_pulse && !start && !abort && col == 10'd527 && (&page[4:0]))
            |=> (!busy && !streaming && !load_req));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !abort) |=> ($stable(col) && $stable(page)));

    // R8
    spare_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (streaming && col >= 10'd512) |-> (dout == 8'hFF));

    // R9
    abort_busy_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (busy && !load_req));
endmodule

bind seqrd_engine seqrd_checks #(.PAGE_W(PAGE_W)) u_checks (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .abort    (abort),
    .rd_pulse (rd_pulse),
    .busy     (busy),
    .streaming(streaming),
    .load_req (load_req),
    .page     (page),
    .col      (col),
    .dout     (dout)
);

// File: tb/seqrd_engine_test.sv
module seqrd_engine_test;
    localparam int PW   = 15;
    localparam int LCYC = 5;
    localparam int RCYC = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    start_mode = 2'd0;
    logic [PW-1:0] start_page = '0;
    logic [7:0]    start_byte = 8'd0;
    logic          abort = 1'b0;
    logic          rd_pulse = 1'b0;
    logic [7:0]    arr_data = 8'h5A;
    logic          busy, streaming, load_req;
    logic [PW-1:0] page;
    logic [9:0]    col;
    logic [7:0]    dout;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    seqrd_engine #(.PAGE_W(PW), .BLK_PAGES(32), .LOAD_CYC(LCYC), .RST_CYC(RCYC)) uut (
        .clk(clk), .rst(rst), .start(start), .start_mode(start_mode),
        .start_page(start_page), .start_byte(start_byte), .abort(abort),
        .rd_pulse(rd_pulse), .arr_data(arr_data), .busy(busy),
        .streaming(streaming), .load_req(load_req), .page(page),
        .col(col), .dout(dout)
    );

    always #5 clk = ~clk;

    // behavioural reference: 0 idle, 1 loading, 2 streaming, 3 resetting
    int m_st = 0, m_cnt = 0, m_page = 0, m_col = 0, m_mode = 0;
    bit m_req = 0;

    always @(posedge clk) begin
        cycles++;
        arr_data <= arr_data + 8'd37;
        m_req = 0;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_page = 0; m_col = 0; m_mode = 0;
        end else if (abort) begin
            m_st = 3; m_cnt = RCYC;
        end else if ((m_st == 0 || m_st == 2) && start) begin
            m_mode = start_mode;
            m_page = start_page;
            if (start_mode == 1)      m_col = 256 + start_byte;
            else if (start_mode == 2) m_col = 512 + (start_byte % 16);
            else                      m_col = start_byte;
            m_st = 1; m_cnt = LCYC; m_req = 1;
        end else if (m_st == 2 && rd_pulse) begin
            if (m_col < 527) m_col++;
            else if (m_page % 32 == 31) m_st = 0;
            else begin
                m_page++;
                m_col = (m_mode == 2) ? 512 : 0;
                m_st = 1; m_cnt = LCYC; m_req = 1;
            end
        end else if (m_st == 1 || m_st == 3) begin
            m_cnt--;
            if (m_cnt == 0) m_st = (m_st == 1) ? 2 : 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            int ed;
            ed = (m_st != 2) ? 0 : (m_col >= 512) ? 255 : int'(arr_data);
            check(busy == (m_st == 1 || m_st == 3), "R2 busy", busy, (m_st == 1 || m_st == 3));
            check(streaming == (m_st == 2), "R6 streaming", streaming, (m_st == 2));
            check(load_req == m_req, "R4 load_req", load_req, m_req);
            check(int'(page) == m_page, "R5 page", page, m_page);
            check(int'(col) == m_col, "R3 col", col, m_col);
            check(int'(dout) == ed, "R8 dout", dout, ed);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input int md, input int pg, input int b);
        @(negedge clk);
        start = 1; start_mode = 2'(md); start_page = PW'(pg); start_byte = 8'(b);
        @(negedge clk);
        start = 0;
    endtask

    task automatic reads(input int n);
        @(negedge clk);
        rd_pulse = 1;
        repeat (n) @(negedge clk);
        rd_pulse = 0;
    endtask

    initial begin
        tick(3);
        // R12 reset state
        check(!busy && !streaming && !load_req, "R12 idle after reset", busy, 0);
        check(page == 0 && col == 0, "R12 zero address", col, 0);
        rst = 0;
        tick(2);

        // R1 R2 mode 0, then page wrap R4 R5
        do_start(0, 5, 250);
        check(busy && load_req, "R2 load request", load_req, 1);
        check(col == 250 && page == 5, "R1 mode0 entry", col, 250);
        tick(LCYC);
        check(streaming, "R2 streaming after load", streaming, 1);
        reads(278);
        check(busy && page == 6 && col == 0, "R5 wrap to column 0", col, 0);
        tick(LCYC + 1);
        reads(10);
        check(col == 10, "R3 advance", col, 10);

        // R11 start and strobe in same cycle while streaming; R1 mode 1
        @(negedge clk);
        rd_pulse = 1; start = 1; start_mode = 2'd1; start_page = PW'(40); start_byte = 8'd10;
        @(negedge clk);
        rd_pulse = 0; start = 0;
        check(col == 266 && page == 40 && busy, "R11 restart wins over strobe", col, 266);
        // R10 start ignored while busy, R7 strobe ignored while busy
        do_start(0, 99, 3);
        reads(1);
        check(page == 40 && col == 266, "R10 start ignored while busy", page, 40);
        tick(LCYC);

        // R1 mode 2 near block end, R5 spare wrap, R6 stop
        do_start(2, 62, 8'hF3);
        check(col == 515, "R1 mode2 entry", col, 515);
        tick(LCYC);
        reads(13);
        check(page == 63 && col == 512 && busy, "R5 spare wrap", col, 512);
        tick(LCYC + 1);
        reads(16);
        check(!busy && !streaming && col == 527, "R6 stop at block end", streaming, 0);
        reads(4);
        check(col == 527 && page == 63, "R7 strobe ignored when stopped", col, 527);

        // R9 abort during load; abort beats start; strobes during reset
        do_start(0, 1, 0);
        @(negedge clk);
        abort = 1; start = 1; start_mode = 2'd1; start_page = PW'(77);
        @(negedge clk);
        abort = 0; start = 0;
        check(busy && page == 1, "R9 abort beats start", page, 1);
        reads(3);
        check(col == 0, "R7 strobe ignored in reset", col, 0);
        tick(RCYC);
        check(!busy && !streaming, "R9 idle after reset interval", busy, 0);

        // abort while streaming with strobe, mode 3 entry
        do_start(3, 300, 200);
        check(col == 200, "R1 mode3 entry", col, 200);
        tick(LCYC);
        @(negedge clk);
        abort = 1; rd_pulse = 1;
        @(negedge clk);
        abort = 0; rd_pulse = 0;
        check(busy && col == 200, "R9 abort beats strobe", col, 200);
        tick(RCYC + 2);
        // start on last load cycle is ignored
        do_start(1, 8, 0);
        tick(LCYC - 2);
        do_start(0, 9, 9);
        check(page == 8, "R10 start on last load cycle", page, 8);
        tick(3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule